// File: doc/BRIEF.md
# Shared Memory Bus Arbiter

This block lets two requesters share one memory bus. The first is a host card-bus port that issues single reads and writes. The second is an embedded controller that fetches from flash and reads and writes SRAM. A host write is parked in a one-entry posted-write buffer, so the host finishes that cycle at once. A host read holds the host in a wait state until the data comes back from memory.

Memory cycles are never preempted. When both sides want the bus, the turn alternates. After a posted write drains, a controller that is waiting therefore goes before a host read that is still pending, and that read goes out only afterwards. A memory cycle lasts one clock plus a programmable wait-state count of 0 to 3. Each region has its own count: addresses with the top bit set are flash, the rest are SRAM. The memory is a small synchronous array inside the block.

Top module: `smb_arbiter`

## Requirements
- R1: After reset, `hst_wait`, `cpu_done`, `hst_rdata` and `cpu_rdata` are all zero.
- R2: A host write strobe that finds the posted-write buffer empty is accepted, and `hst_wait` stays low in the following cycle.
- R3: A memory cycle that has started runs to completion. A posted write that arrives while the controller owns the bus does not lengthen or disturb that controller access.
- R4: A host read never overtakes a buffered write. It is issued only once the buffer is empty, so a read of a just-written address returns the written data.
- R5: When a host access completes while the controller is requesting, the controller gets the next bus turn. This holds even when a host read is waiting.
- R6: A lone requester gets consecutive turns with no extra delay: every controller access on an idle bus has the same latency, back to back.
- R7: `hst_wait` is high in the cycle after a rising read strobe. It stays high until the read data is on `hst_rdata`, and that data then stays stable while the strobe remains high.
- R8: A host write that arrives while the buffer is full is stalled with `hst_wait` until the buffer drains. It is then accepted, and both writes reach memory in order.
- R9: Each memory cycle takes (wait states + 1) clocks. An address with bit AW-1 set uses `ws_flash`; other addresses use `ws_sram`. On an idle bus, `cpu_done` pulses in cycle ws+2 after `cpu_req` rises.
- R10: Controller writes update memory. Controller reads return the latest value written by either requester on `cpu_rdata` when `cpu_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_flash | input | 2 | Wait states for flash-region cycles |
| ws_sram | input | 2 | Wait states for SRAM-region cycles |
| hst_rd | input | 1 | Host read strobe, held until data is returned |
| hst_wr | input | 1 | Host write strobe, held while `hst_wait` is high |
| hst_addr | input | 6 | Host word address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_wait | output | 1 | Wait state to the host |
| cpu_req | input | 1 | Controller request, held until `cpu_done` |
| cpu_we | input | 1 | Controller write enable |
| cpu_addr | input | 6 | Controller word address |
| cpu_wdata | input | 16 | Controller write data |
| cpu_rdata | output | 16 | Controller read data |
| cpu_done | output | 1 | One-cycle completion pulse to the controller |

## Verification
The assertions assume three things about the inputs. The host runs one cycle at a time. A strobe drops for at least one clock between host cycles. The controller keeps `cpu_req`, address and data steady from raising the request until it sees `cpu_done`. The bench drives both sides through tasks that follow these rules, with random addresses, data and wait-state settings from a fixed seed. Overlap between the host and the controller is produced only in the directed cases, where a forked controller thread and host thread are timed to force the posted-write, stalled-write and waiting-read orderings.

// File: rtl/smb_pkg.sv
package smb_pkg;
   typedef enum logic [1:0] {
      OWN_CPU = 2'd0,
      OWN_HWR = 2'd1,
      OWN_HRD = 2'd2
   } owner_e;
endpackage

// File: rtl/smb_mem_model.sv
module smb_mem_model #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/smb_host_port.sv
module smb_host_port #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_rd,
   input  logic          hst_wr,
   input  logic [AW-1:0] hst_addr,
   input  logic [DW-1:0] hst_wdata,
   input  logic          wdone,
   input  logic          rdone,
   input  logic [DW-1:0] mem_rdata,
   output logic          hst_wait,
   output logic [DW-1:0] hst_rdata,
   output logic          wreq,
   output logic          rreq,
   output logic [AW-1:0] wbuf_addr,
   output logic [DW-1:0] wbuf_data,
   output logic [AW-1:0] rd_addr
);
   logic rd_q, wr_q, rd_seen, wr_seen;
   logic wbuf_v, wr_stall, rd_pend;

   assign rd_seen = hst_rd && !rd_q;
   assign wr_seen = hst_wr && !wr_q;
   assign wreq    = wbuf_v;
   assign rreq    = rd_pend && !wbuf_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         wr_q      <= 1'b0;
         wbuf_v    <= 1'b0;
         wr_stall  <= 1'b0;
         rd_pend   <= 1'b0;
         hst_wait  <= 1'b0;
         hst_rdata <= '0;
         wbuf_addr <= '0;
         wbuf_data <= '0;
         rd_addr   <= '0;
      end else begin
         rd_q <= hst_rd;
         wr_q <= hst_wr;
         if (wdone) wbuf_v <= 1'b0;
         if (wr_seen && !wbuf_v) begin
            wbuf_v    <= 1'b1;
            wbuf_addr <= hst_addr;
            wbuf_data <= hst_wdata;
         end else if (wr_seen) begin
            wr_stall <= 1'b1;
            hst_wait <= 1'b1;
         end
         if (wr_stall && !wbuf_v) begin
            wbuf_v    <= 1'b1;
            wbuf_addr <= hst_addr;
            wbuf_data <= hst_wdata;
            wr_stall  <= 1'b0;
            hst_wait  <= 1'b0;
         end
         if (rd_seen) begin
            rd_pend  <= 1'b1;
            rd_addr  <= hst_addr;
            hst_wait <= 1'b1;
         end
         if (rdone) begin
            rd_pend   <= 1'b0;
            hst_rdata <= mem_rdata;
            hst_wait  <= 1'b0;
         end
      end
   end

   // R7: wait follows a new read strobe by one cycle
   assert_wait_after_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_seen |=> hst_wait)
      else $error("read strobe not followed by wait");

   // R8: a full buffer is never overwritten before it drains
   assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wbuf_v && !wdone) |=> (wbuf_v && $stable(wbuf_addr) && $stable(wbuf_data)))
      else $error("posted write overwritten");

   // R4: a read completes only with no write left in the buffer
   assert_rd_after_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rdone |-> !wbuf_v)
      else $error("read overtook posted write");
endmodule

// File: rtl/smb_bus_seq.sv
module smb_bus_seq
   import smb_pkg::*;
#(
   parameter int AW   = 6,
   parameter int DW   = 16,
   parameter int WS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WS_W-1:0] ws_flash,
   input  logic [WS_W-1:0] ws_sram,
   input  logic            cpu_req,
   input  logic            cpu_we,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   input  logic            wreq,
   input  logic            rreq,
   input  logic [AW-1:0]   wbuf_addr,
   input  logic [DW-1:0]   wbuf_data,
   input  logic [AW-1:0]   rd_addr,
   input  logic [DW-1:0]   mem_rdata,
   output logic            mem_en,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic            wdone,
   output logic            rdone,
   output logic            cpu_done,
   output logic [DW-1:0]   cpu_rdata
);
   localparam int FLASH_BIT = AW - 1;

   logic            busy, last_host, pick_host, host_any, finish;
   owner_e          own, nxt_own;
   logic [WS_W-1:0] cnt, nxt_ws;
   logic [AW-1:0]   a_addr, nxt_addr;
   logic [DW-1:0]   a_data, nxt_data;
   logic            a_we, nxt_we;

   always_comb begin
      host_any  = wreq || rreq;
      pick_host = host_any && (!cpu_req || !last_host);
      if (pick_host && wreq) begin
         nxt_own  = OWN_HWR;
         nxt_addr = wbuf_addr;
         nxt_data = wbuf_data;
         nxt_we   = 1'b1;
      end else if (pick_host) begin
         nxt_own  = OWN_HRD;
         nxt_addr = rd_addr;
         nxt_data = '0;
         nxt_we   = 1'b0;
      end else begin
         nxt_own  = OWN_CPU;
         nxt_addr = cpu_addr;
         nxt_data = cpu_wdata;
         nxt_we   = cpu_we;
      end
      nxt_ws = nxt_addr[FLASH_BIT] ? ws_flash : ws_sram;
   end

   assign finish    = busy && (cnt == '0);
   assign mem_en    = finish;
   assign mem_we    = finish && a_we;
   assign mem_addr  = a_addr;
   assign mem_wdata = a_data;
   assign wdone     = finish && (own == OWN_HWR);
   assign rdone     = finish && (own == OWN_HRD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         last_host <= 1'b0;
         own       <= OWN_CPU;
         cnt       <= '0;
         a_addr    <= '0;
         a_data    <= '0;
         a_we      <= 1'b0;
         cpu_done  <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         cpu_done <= finish && (own == OWN_CPU);
         if (finish && (own == OWN_CPU)) cpu_rdata <= mem_rdata;
         if (!busy && (cpu_req || host_any)) begin
            busy      <= 1'b1;
            own       <= nxt_own;
            last_host <= pick_host;
            a_addr    <= nxt_addr;
            a_data    <= nxt_data;
            a_we      <= nxt_we;
            cnt       <= nxt_ws;
         end else if (finish) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R3: an access in progress keeps its owner and address
   assert_nonpreempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> (busy && $stable(own) && $stable(a_addr)))
      else $error("access preempted");

   // R5: host turn is followed by a controller turn when it waits
   assert_rr_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && own != OWN_CPU && cpu_req) |=> ##1 (busy && own == OWN_CPU))
      else $error("controller skipped after host turn");

   // R6: a lone controller request is granted on the next edge
   assert_lone_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cpu_req && !wreq && !rreq) |=> (busy && own == OWN_CPU))
      else $error("lone request not granted");
endmodule

// File: rtl/smb_arbiter.sv
module smb_arbiter #(
   parameter int AW   = 6,
   parameter int DW   = 16,
   parameter int WS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WS_W-1:0] ws_flash,
   input  logic [WS_W-1:0] ws_sram,
   input  logic            hst_rd,
   input  logic            hst_wr,
   input  logic [AW-1:0]   hst_addr,
   input  logic [DW-1:0]   hst_wdata,
   output logic [DW-1:0]   hst_rdata,
   output logic            hst_wait,
   input  logic            cpu_req,
   input  logic            cpu_we,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic [DW-1:0]   cpu_rdata,
   output logic            cpu_done
);
   generate
      if (AW < 2 || AW > 12) begin : g_bad_aw
         $error("AW must lie in 2..12");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
      if (WS_W < 1 || WS_W > 4) begin : g_bad_ws
         $error("WS_W must lie in 1..4");
      end
   endgenerate

   logic          wdone, rdone, wreq, rreq;
   logic          mem_en, mem_we;
   logic [AW-1:0] wbuf_addr, rd_addr, mem_addr;
   logic [DW-1:0] wbuf_data, mem_wdata, mem_rdata;

   smb_host_port #(.AW(AW), .DW(DW)) u_host (
      .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .wdone(wdone), .rdone(rdone),
      .mem_rdata(mem_rdata), .hst_wait(hst_wait), .hst_rdata(hst_rdata),
      .wreq(wreq), .rreq(rreq), .wbuf_addr(wbuf_addr), .wbuf_data(wbuf_data),
      .rd_addr(rd_addr)
   );

   smb_bus_seq #(.AW(AW), .DW(DW), .WS_W(WS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ws_flash(ws_flash), .ws_sram(ws_sram),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .wreq(wreq), .rreq(rreq), .wbuf_addr(wbuf_addr),
      .wbuf_data(wbuf_data), .rd_addr(rd_addr), .mem_rdata(mem_rdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .wdone(wdone), .rdone(rdone),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata)
   );

   smb_mem_model #(.AW(AW), .DW(DW)) u_mem (
      .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
      .wdata(mem_wdata), .rdata(mem_rdata)
   );
endmodule

// File: tb/tb_smb_arbiter.sv
module tb_smb_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ws_flash = '0, ws_sram = '0;
   logic        hst_rd = 1'b0, hst_wr = 1'b0;
   logic [5:0]  hst_addr = '0;
   logic [15:0] hst_wdata = '0;
   logic [15:0] hst_rdata;
   logic        hst_wait;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [5:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        cpu_done;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   logic [15:0] shadow [64];

   always #2 clk = ~clk;

   smb_arbiter dut (
      .clk(clk), .rst_n(rst_n), .ws_flash(ws_flash), .ws_sram(ws_sram),
      .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_wait(hst_wait),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done)
   );

   function automatic int exp_lat(input logic [5:0] a, input logic [1:0] wf,
                                  input logic [1:0] wsr);
      return (a[5] ? int'(wf) : int'(wsr)) + 2;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cpu_op(input bit we, input logic [5:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output int lat);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!cpu_done);
      cpu_req = 1'b0;
      rd = cpu_rdata;
   endtask

   task automatic host_write(input logic [5:0] a, input logic [15:0] d,
                             output bit stalled);
      @(negedge clk);
      hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
      stalled = 1'b0;
      @(negedge clk);
      while (hst_wait) begin
         stalled = 1'b1;
         @(negedge clk);
      end
      hst_wr = 1'b0;
   endtask

   task automatic host_read(input logic [5:0] a, output logic [15:0] d,
                            output bit w1);
      @(negedge clk);
      hst_rd = 1'b1; hst_addr = a;
      @(negedge clk);
      w1 = hst_wait;
      while (hst_wait) @(negedge clk);
      d = hst_rdata;
      @(negedge clk);
      chk(hst_rdata === d, "R7 data held while strobe high", int'(hst_rdata), int'(d));
      hst_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] rd, d1;
      int lat, lat2;
      bit st, w1;
      time t_c2, t_rd;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      chk(hst_wait === 1'b0, "R1 hst_wait", int'(hst_wait), 0);
      chk(cpu_done === 1'b0, "R1 cpu_done", int'(cpu_done), 0);
      chk(hst_rdata === 16'h0, "R1 hst_rdata", int'(hst_rdata), 0);
      chk(cpu_rdata === 16'h0, "R1 cpu_rdata", int'(cpu_rdata), 0);

      // fill memory through controller writes (R10)
      for (int i = 0; i < 64; i++) begin
         shadow[i] = 16'(i * 16'h0101 + 16'h5a);
         cpu_op(1'b1, 6'(i), shadow[i], rd, lat);
      end
      cpu_op(1'b0, 6'd17, 16'h0, rd, lat);
      chk(rd === shadow[17], "R10 controller read after fill", int'(rd), int'(shadow[17]));

      // R9 and R6: latency per region and setting, back to back
      for (int f = 0; f < 4; f++) begin
         for (int s = 0; s < 4; s++) begin
            ws_flash = 2'(f); ws_sram = 2'(s);
            cpu_op(1'b0, 6'd40, 16'h0, rd, lat);
            chk(lat == exp_lat(6'd40, 2'(f), 2'(s)), "R9 flash latency", lat, exp_lat(6'd40, 2'(f), 2'(s)));
            cpu_op(1'b0, 6'd3, 16'h0, rd, lat);
            chk(lat == exp_lat(6'd3, 2'(f), 2'(s)), "R9 sram latency", lat, exp_lat(6'd3, 2'(f), 2'(s)));
            cpu_op(1'b0, 6'd3, 16'h0, rd, lat2);
            chk(lat2 == lat, "R6 back-to-back lone latency", lat2, lat);
         end
      end

      // Directed: posted write during controller access, read waits, controller goes first
      ws_flash = 2'd3; ws_sram = 2'd3;
      fork
         begin
            cpu_op(1'b0, 6'd44, 16'h0, rd, lat);
            chk(lat == 5, "R3 controller access not lengthened by posted write", lat, 5);
            chk(rd === shadow[44], "R10 controller read data", int'(rd), int'(shadow[44]));
            cpu_op(1'b0, 6'd45, 16'h0, rd, lat2);
            t_c2 = $time;
         end
         begin
            @(negedge clk);
            host_write(6'd5, 16'hbeef, st);
            chk(st == 1'b0, "R2 posted write accepted without wait", int'(st), 0);
            shadow[5] = 16'hbeef;
            host_read(6'd5, d1, w1);
            t_rd = $time;
            chk(w1 == 1'b1, "R7 wait after read strobe", int'(w1), 1);
            chk(d1 === 16'hbeef, "R4 read returns posted write data", int'(d1), 16'hbeef);
         end
      join
      chk(t_c2 < t_rd, "R5 controller turn before waiting host read", int'(t_c2), int'(t_rd));

      // Directed: second write while buffer full is stalled
      fork
         begin
            cpu_op(1'b0, 6'd50, 16'h0, rd, lat);
         end
         begin
            @(negedge clk);
            host_write(6'd7, 16'h1111, st);
            chk(st == 1'b0, "R2 first write no wait", int'(st), 0);
            host_write(6'd8, 16'h2222, st);
            chk(st == 1'b1, "R8 second write stalled", int'(st), 1);
         end
      join
      shadow[7] = 16'h1111; shadow[8] = 16'h2222;
      host_read(6'd7, d1, w1);
      chk(d1 === 16'h1111, "R8 first buffered write landed", int'(d1), 16'h1111);
      host_read(6'd8, d1, w1);
      chk(d1 === 16'h2222, "R8 stalled write landed", int'(d1), 16'h2222);
      cpu_op(1'b0, 6'd8, 16'h0, rd, lat);
      chk(rd === 16'h2222, "R10 controller sees host write", int'(rd), 16'h2222);

      // Random sequential traffic
      for (int it = 0; it < 200; it++) begin
         logic [5:0]  a;
         logic [15:0] d;
         a = 6'($urandom % 64);
         d = 16'($urandom);
         @(negedge clk);
         ws_flash = 2'($urandom % 4); ws_sram = 2'($urandom % 4);
         case ($urandom % 4)
            0: begin
               cpu_op(1'b1, a, d, rd, lat);
               shadow[a] = d;
               chk(lat == exp_lat(a, ws_flash, ws_sram), "R9 random write latency", lat, exp_lat(a, ws_flash, ws_sram));
            end
            1: begin
               cpu_op(1'b0, a, 16'h0, rd, lat);
               chk(rd === shadow[a], "R10 random controller read", int'(rd), int'(shadow[a]));
               chk(lat == exp_lat(a, ws_flash, ws_sram), "R9 random read latency", lat, exp_lat(a, ws_flash, ws_sram));
            end
            2: begin
               host_write(a, d, st);
               shadow[a] = d;
               chk(st == 1'b0, "R2 random host write no wait", int'(st), 0);
               repeat (7) @(negedge clk);
            end
            default: begin
               host_read(a, d1, w1);
               chk(w1 == 1'b1, "R7 random read wait", int'(w1), 1);
               chk(d1 === shadow[a], "R4 random host read data", int'(d1), int'(shadow[a]));
            end
         endcase
      end
      finish_run();
   end
endmodule